// File: doc/BRIEF.md
# Multi-Channel DMA Status and Control Register Bank

This block is the software-visible control and status bank of a multi-channel DMA controller. It keeps, for every channel, an enable bit, an interrupt-enable bit and three event flags: error, completion interrupt A and completion interrupt B. Software changes the enable and interrupt-enable vectors through separate set and clear addresses. It acknowledges flags by writing ones to them. The channel engines raise the flags with one-cycle hardware set pulses, and they report their live active and busy state, which software can only read.

Three write-only addresses turn each one bit written into a single-cycle command pulse to the matching channel: mark the descriptor valid, trigger the channel, or abort it. A global run bit gates every channel's permission to start. A summary word folds the enabled completion flags and the error flags into two pending bits, and their OR drives one interrupt line. Access is through a simple word-addressed bus: write enable, address and write data, with read data decoded combinationally from the address. Bit n of every vector belongs to channel n.

Top module: `dma_ctrl_bank`

## Requirements
- R1: After reset every stored vector, the run bit, all command pulses, the summary word, `chan_go` and `irq` are zero.
- R2: A write to address 2 sets the enable of every channel whose data bit is 1. A write to address 3 clears the enable of every channel whose data bit is 1. Data bits that are 0 leave those channels unchanged. Reading address 2 returns the enable vector, and `chan_en` shows it from the cycle after the write.
- R3: Interrupt-enable works in the same way, with set address 7 and clear address 8. Reading address 7 returns the interrupt-enable vector.
- R4: The error flags (address 6), the A flags (address 9) and the B flags (address 10) are set by `hw_err_set`, `hw_inta_set` and `hw_intb_set`. Writing a 1 to a flag's bit at its address clears that flag. Written 0 bits have no effect. Reading the address returns the flag vector.
- R5: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: A write to address 11 (valid), 12 (trigger) or 13 (abort) raises `valid_pulse`, `trig_pulse` or `abort_pulse` for exactly the one cycle after the write, on exactly the written bits. These addresses read as zero.
- R7: Address 1 reads the summary word. Bit 1 is 1 when any channel with its interrupt enable set has its A or B flag set. Bit 2 is 1 when any error flag is set. All other bits are 0.
- R8: `irq` is 1 exactly when summary bit 1 or bit 2 is 1.
- R9: Bit 0 of address 0 is the global run bit, and it reads back at bit 0 of address 0. `ctrl_on` shows the run bit. `chan_go` equals `chan_en` while the run bit is 1 and is all zero while it is 0.
- R10: Address 4 reads `chan_active` and address 5 reads `chan_busy`, zero-extended. Addresses 14 and 15 read as zero, and writes to the read-only addresses 1, 4 and 5 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hw_err_set | input | 16 | Per-channel error flag set pulses |
| hw_inta_set | input | 16 | Per-channel interrupt A set pulses |
| hw_intb_set | input | 16 | Per-channel interrupt B set pulses |
| chan_active | input | 16 | Per-channel transfer-in-progress status |
| chan_busy | input | 16 | Per-channel pipeline-occupied status |
| chan_en | output | 16 | Per-channel enable vector |
| chan_go | output | 16 | Per-channel start permission, enable gated by the run bit |
| ctrl_on | output | 1 | Global run bit |
| valid_pulse | output | 16 | One-cycle descriptor-valid commands |
| trig_pulse | output | 16 | One-cycle trigger commands |
| abort_pulse | output | 16 | One-cycle abort commands |
| irq | output | 1 | Combined interrupt |

## Verification
The case that needs the most care is a hardware flag set that lands in the same cycle as a software write-one-to-clear of the same flag vector. The bench provokes this by driving hardware set pulses in the same cycle as writes to the error, A and B flag addresses, both on overlapping bits and on disjoint bits. It then judges the result by reading the flag back and checking the summary word and `irq`. A reference model in the bench applies the clear first and then ORs in the set. Long pseudo-random mixes of writes to every address, hardware sets, and active and busy patterns are compared, after every step, against that model on every readable address and output.

// File: rtl/dma_bank_pkg.sv
// Package: dma_bank_pkg
// Word addresses of the DMA control bank. Addresses that the bench and
// driver software depend on are fixed here once.
package dma_bank_pkg;
    localparam int ADR_CTRL    = 0;
    localparam int ADR_SUMMARY = 1;
    localparam int ADR_EN_SET  = 2;
    localparam int ADR_EN_CLR  = 3;
    localparam int ADR_ACTIVE  = 4;
    localparam int ADR_BUSY    = 5;
    localparam int ADR_ERR     = 6;
    localparam int ADR_IE_SET  = 7;
    localparam int ADR_IE_CLR  = 8;
    localparam int ADR_INTA    = 9;
    localparam int ADR_INTB    = 10;
    localparam int ADR_VALID   = 11;
    localparam int ADR_TRIG    = 12;
    localparam int ADR_ABORT   = 13;

    // Index of each hardware-set flag vector in the flag array.
    localparam int FLG_ERR  = 0;
    localparam int FLG_INTA = 1;
    localparam int FLG_INTB = 2;
    localparam int NUM_FLG  = 3;
endpackage

// File: rtl/dma_setclr_vec.sv
// Module: dma_setclr_vec
// Holds a vector that software changes through a set port and a clear
// port. One bits of the data act; zero bits leave the vector alone.
// Assumes set_en and clr_en are never high in the same cycle (they come
// from decodes of different addresses).
module dma_setclr_vec #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] vec
);
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;

    // Qualify the data bits with the two strobes.
    always_comb begin
        set_mask = set_en ? bits : '0;
        clr_mask = clr_en ? bits : '0;
    end

    // Store the vector with set and clear masks applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec <= '0;
        end else begin
            vec <= (vec | set_mask) & ~clr_mask;
        end
    end
endmodule

// File: rtl/dma_flag_vec.sv
// Module: dma_flag_vec
// Per-channel event flags. Hardware sets a flag with a one-cycle pulse;
// software clears it by writing a one. A set in the same cycle as a
// clear wins, so no event is lost.
module dma_flag_vec #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // One flag bit: the hardware set dominates the software clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (hw_set[i]) begin
                    flags[i] <= 1'b1;
                end else if (clr_en && clr_bits[i]) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dma_pulse_vec.sv
// Module: dma_pulse_vec
// Turns a write to a command address into a one-cycle pulse on each
// written one bit, issued in the cycle after the write.
module dma_pulse_vec #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] bits,
    output logic [W-1:0] pulse
);
    // Register the command bits for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= '0;
        end else begin
            pulse <= fire ? bits : '0;
        end
    end
endmodule

// File: rtl/dma_ctrl_bank.sv
// Module: dma_ctrl_bank
// Control and status register bank for a multi-channel DMA controller.
// Decodes a word-addressed write bus into set/clear, write-one-to-clear
// and command-pulse actions. Serves combinational read data and drives a
// summary word and one interrupt line. Assumes NCH < DATA_W, and that the
// bus presents one access per cycle with no handshake.
module dma_ctrl_bank #(
    parameter int NCH    = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    hw_err_set,
    input  logic [NCH-1:0]    hw_inta_set,
    input  logic [NCH-1:0]    hw_intb_set,
    input  logic [NCH-1:0]    chan_active,
    input  logic [NCH-1:0]    chan_busy,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    chan_go,
    output logic              ctrl_on,
    output logic [NCH-1:0]    valid_pulse,
    output logic [NCH-1:0]    trig_pulse,
    output logic [NCH-1:0]    abort_pulse,
    output logic              irq
);
    import dma_bank_pkg::*;

    localparam int NREG = 2 ** ADDR_W;

    logic [NREG-1:0]           wr_hit;
    logic [NCH-1:0]            wbits;
    logic [NCH-1:0]            ie_q;
    logic [NCH-1:0]            err_q;
    logic [NCH-1:0]            inta_q;
    logic [NCH-1:0]            intb_q;
    logic [NUM_FLG-1:0][NCH-1:0] flg_set;
    logic [NUM_FLG-1:0][NCH-1:0] flg_q;
    logic [NUM_FLG-1:0]          flg_clr;
    logic                      run_q;
    logic                      ab_pending;
    logic                      err_pending;
    logic [DATA_W-1:0]         summary;
    logic                      unused_wdata;

    assign wbits        = bus_wdata[NCH-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:NCH];

    // One-hot write decode of the address.
    always_comb begin
        wr_hit = '0;
        if (bus_we) begin
            wr_hit[bus_addr] = 1'b1;
        end
    end

    // Global run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_hit[ADR_CTRL]) begin
            run_q <= bus_wdata[0];
        end
    end

    dma_setclr_vec #(.W(NCH)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_hit[ADR_EN_SET]),
        .clr_en (wr_hit[ADR_EN_CLR]),
        .bits   (wbits),
        .vec    (chan_en)
    );

    dma_setclr_vec #(.W(NCH)) u_ie (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_hit[ADR_IE_SET]),
        .clr_en (wr_hit[ADR_IE_CLR]),
        .bits   (wbits),
        .vec    (ie_q)
    );

    // Route hardware sets and software clears to the flag array.
    always_comb begin
        flg_set[FLG_ERR]  = hw_err_set;
        flg_set[FLG_INTA] = hw_inta_set;
        flg_set[FLG_INTB] = hw_intb_set;
        flg_clr[FLG_ERR]  = wr_hit[ADR_ERR];
        flg_clr[FLG_INTA] = wr_hit[ADR_INTA];
        flg_clr[FLG_INTB] = wr_hit[ADR_INTB];
    end

    genvar f;
    generate
        for (f = 0; f < NUM_FLG; f++) begin : g_flag
            dma_flag_vec #(.W(NCH)) u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_en   (flg_clr[f]),
                .clr_bits (wbits),
                .hw_set   (flg_set[f]),
                .flags    (flg_q[f])
            );
        end
    endgenerate

    assign err_q  = flg_q[FLG_ERR];
    assign inta_q = flg_q[FLG_INTA];
    assign intb_q = flg_q[FLG_INTB];

    dma_pulse_vec #(.W(NCH)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_hit[ADR_VALID]),
        .bits  (wbits),
        .pulse (valid_pulse)
    );

    dma_pulse_vec #(.W(NCH)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_hit[ADR_TRIG]),
        .bits  (wbits),
        .pulse (trig_pulse)
    );

    dma_pulse_vec #(.W(NCH)) u_abort (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_hit[ADR_ABORT]),
        .bits  (wbits),
        .pulse (abort_pulse)
    );

    // Fold enabled completion flags and error flags into the summary.
    always_comb begin
        ab_pending  = |((inta_q | intb_q) & ie_q);
        err_pending = |err_q;
        summary     = '0;
        summary[1]  = ab_pending;
        summary[2]  = err_pending;
    end

    assign irq     = ab_pending | err_pending;
    assign ctrl_on = run_q;
    assign chan_go = chan_en & {NCH{run_q}};

    // Combinational read mux; unmapped and write-only addresses read zero.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_CTRL:    bus_rdata[0] = run_q;
            ADR_SUMMARY: bus_rdata = summary;
            ADR_EN_SET:  bus_rdata[NCH-1:0] = chan_en;
            ADR_ACTIVE:  bus_rdata[NCH-1:0] = chan_active;
            ADR_BUSY:    bus_rdata[NCH-1:0] = chan_busy;
            ADR_ERR:     bus_rdata[NCH-1:0] = err_q;
            ADR_IE_SET:  bus_rdata[NCH-1:0] = ie_q;
            ADR_INTA:    bus_rdata[NCH-1:0] = inta_q;
            ADR_INTB:    bus_rdata[NCH-1:0] = intb_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_ctrl_bank_chk.sv
// Module: dma_ctrl_bank_chk
// Assertion checker for dma_ctrl_bank, attached by bind. It observes
// ports and the stored flag and enable vectors.
module dma_ctrl_bank_chk #(
    parameter int NCH    = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCH-1:0]    hw_err_set,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    chan_go,
    input logic              ctrl_on,
    input logic [NCH-1:0]    err_q,
    input logic [NCH-1:0]    inta_q,
    input logic [NCH-1:0]    intb_q,
    input logic [NCH-1:0]    ie_q,
    input logic [NCH-1:0]    abort_pulse,
    input logic              irq
);
    import dma_bank_pkg::*;

    logic [NCH-1:0] wlo;
    logic           unused_hi;
    assign wlo       = bus_wdata[NCH-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:NCH];

    // R2: enable-set write leaves every written channel enabled.
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(ADR_EN_SET)) |=> ((chan_en & $past(wlo)) == $past(wlo)));

    // R5: a hardware error set always leaves the flag set.
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_err_set) |=> ((err_q & $past(hw_err_set)) == $past(hw_err_set)));

    // R6: an abort pulse only follows a write to the abort address.
    assert_abort_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort_pulse) |-> $past(bus_we && bus_addr == ADDR_W'(ADR_ABORT)));

    // R8: the interrupt line needs a pending error or enabled completion.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|err_q) || (|((inta_q | intb_q) & ie_q))));

    // R9: no channel may start while the controller is stopped.
    assert_go_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_go) |-> ctrl_on);
endmodule

bind dma_ctrl_bank dma_ctrl_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_ctrl_bank_tb.sv
// Bench: dma_ctrl_bank_tb
// Walking-bit sweeps and a long pseudo-random mix, compared after each
// step against a reference model built from the requirements.
module dma_ctrl_bank_tb;
    localparam int NCH    = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    hw_err_set, hw_inta_set, hw_intb_set;
    logic [NCH-1:0]    chan_active, chan_busy;
    logic [NCH-1:0]    chan_en, chan_go, valid_pulse, trig_pulse, abort_pulse;
    logic              ctrl_on, irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state.
    logic [NCH-1:0] m_en, m_ie, m_err, m_a, m_b;
    logic           m_run;
    logic [31:0]    seed = 32'h1357_9bdf;

    always #5 clk = ~clk;

    dma_ctrl_bank #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Read one address combinationally (called between edges, we low).
    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    // Compare every readable address and every output with the model.
    task automatic check_all();
        logic [DATA_W-1:0] d;
        logic sa, se;
        sa = |((m_a | m_b) & m_ie);
        se = |m_err;
        rd(0, d);  chk("R9 run readback", d, {31'b0, m_run});
        rd(1, d);  chk("R7 summary", d, {29'b0, se, sa, 1'b0});
        rd(2, d);  chk("R2 enable readback", d, {16'b0, m_en});
        rd(3, d);  chk("R10 enable-clear reads zero", d, '0);
        rd(4, d);  chk("R10 active readback", d, {16'b0, chan_active});
        rd(5, d);  chk("R10 busy readback", d, {16'b0, chan_busy});
        rd(6, d);  chk("R4 error flags", d, {16'b0, m_err});
        rd(7, d);  chk("R3 int-enable readback", d, {16'b0, m_ie});
        rd(9, d);  chk("R4 A flags", d, {16'b0, m_a});
        rd(10, d); chk("R4 B flags", d, {16'b0, m_b});
        rd(13, d); chk("R6 abort reads zero", d, '0);
        rd(15, d); chk("R10 unmapped reads zero", d, '0);
        chk("R2 chan_en port", 32'(chan_en), 32'(m_en));
        chk("R9 chan_go", 32'(chan_go), 32'(m_en & {NCH{m_run}}));
        chk("R9 ctrl_on", 32'(ctrl_on), 32'(m_run));
        chk("R8 irq", 32'(irq), 32'(sa | se));
    endtask

    // One bus cycle with optional write and hardware sets; model updated,
    // pulses checked in the cycle after the write and the one after that.
    task automatic step(input bit we, input int a, input logic [DATA_W-1:0] wd,
                        input logic [NCH-1:0] e, input logic [NCH-1:0] ia, input logic [NCH-1:0] ib);
        logic [NCH-1:0] w;
        w = wd[NCH-1:0];
        @(negedge clk);
        bus_we = we; bus_addr = ADDR_W'(a); bus_wdata = wd;
        hw_err_set = e; hw_inta_set = ia; hw_intb_set = ib;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        hw_err_set = '0; hw_inta_set = '0; hw_intb_set = '0;
        if (we) begin
            case (a)
                0:  m_run = wd[0];
                2:  m_en  = m_en | w;
                3:  m_en  = m_en & ~w;
                6:  m_err = m_err & ~w;
                7:  m_ie  = m_ie | w;
                8:  m_ie  = m_ie & ~w;
                9:  m_a   = m_a & ~w;
                10: m_b   = m_b & ~w;
                default: ;
            endcase
        end
        m_err = m_err | e;   // R5: set applied after clear
        m_a   = m_a | ia;
        m_b   = m_b | ib;
        #1;
        chk("R6 valid pulse", 32'(valid_pulse), 32'((we && a == 11) ? w : '0));
        chk("R6 trig pulse",  32'(trig_pulse),  32'((we && a == 12) ? w : '0));
        chk("R6 abort pulse", 32'(abort_pulse), 32'((we && a == 13) ? w : '0));
        @(negedge clk);
        #1;
        chk("R6 pulse one cycle", 32'(valid_pulse | trig_pulse | abort_pulse), '0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        hw_err_set = '0; hw_inta_set = '0; hw_intb_set = '0;
        chan_active = '0; chan_busy = '0;
        m_en = '0; m_ie = '0; m_err = '0; m_a = '0; m_b = '0; m_run = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 pulses zero", 32'(valid_pulse | trig_pulse | abort_pulse), '0);
        check_all();

        // R2/R9: walking enable set, then clear, with run off and on.
        for (int n = 0; n < NCH; n++) begin
            step(1, 2, 32'(1) << n, '0, '0, '0);
            check_all();
        end
        step(1, 0, 32'h1, '0, '0, '0);   check_all();
        step(1, 2, 32'h0, '0, '0, '0);   check_all(); // R2 zero bits ignored
        for (int n = 0; n < NCH; n += 2) begin
            step(1, 3, 32'(1) << n, '0, '0, '0);
            check_all();
        end
        step(1, 0, 32'h0, '0, '0, '0);   check_all();

        // R3/R4/R7: walking flags with interrupt enable toggled.
        for (int n = 0; n < NCH; n++) begin
            step(1, 7, 32'(1) << n, '0, 16'(1) << n, '0);
            check_all();
            step(1, 9, 32'(1) << n, '0, '0, 16'(1) << n);
            check_all();
            step(1, 8, 32'(1) << n, 16'(1) << n, '0, '0);
            check_all();
            step(1, 6, 32'(1) << n, '0, '0, '0);
            check_all();
            step(1, 10, 32'(1) << n, '0, '0, '0);
            check_all();
        end

        // R5: hardware set and clear in the same cycle, same and other bits.
        step(1, 6, 32'hFFFF, 16'h00F0, '0, '0);      check_all();
        step(1, 9, 32'hFFFF, '0, 16'h0101, '0);      check_all();
        step(1, 10, 32'h00FF, '0, '0, 16'h8001);     check_all();
        step(1, 6, 32'h00F0, 16'h0F00, '0, '0);      check_all();

        // R6: walking command pulses at each command address.
        for (int n = 0; n < NCH; n++) begin
            step(1, 11 + (n % 3), 32'(1) << n, '0, '0, '0);
        end

        // R10: writes to read-only addresses change nothing.
        step(1, 1, 32'hFFFF_FFFF, '0, '0, '0);  check_all();
        step(1, 4, 32'hFFFF_FFFF, '0, '0, '0);  check_all();
        step(1, 5, 32'hFFFF_FFFF, '0, '0, '0);  check_all();

        // Pseudo-random mix of all functions.
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] r1, r2;
            seed = nxt(seed); r1 = seed;
            seed = nxt(seed); r2 = seed;
            chan_active = r2[15:0];
            chan_busy   = r2[31:16];
            step(r1[0], int'(r1[4:1]), {r2[7:0], r2[31:8]},
                 r1[15:0] & r2[15:0] & {16{r1[5]}},
                 r1[31:16] & r2[31:16] & {16{r1[6]}},
                 r1[15:0] & r2[31:16] & {16{r1[7]}});
            check_all();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule